// File: doc/BRIEF.md
# Sliced 16-bit Arithmetic and Logic Unit

This block computes one of six functions on two 16-bit operands: add, subtract, bitwise AND, bitwise OR, and a one-position shift of the first operand to the left or to the right. Arithmetic and bitwise work runs through four 4-bit slices chained on a rippled carry, from the low nibble up to the high nibble. Two single-position shifters sit beside the slice chain. A result multiplexer picks the slice chain, one of the shifters, or a constant zero.

A small lookup decoder turns the 3-bit function code into the slice mode, the operand inversion, the carry-in and the multiplexer select. Subtraction adds the first operand to the inverted second operand with a carry-in of one.

Operands enter on a valid/ready stream. Results leave on a second valid/ready stream through one output register. A new operation is accepted whenever the output register is empty or is being drained in the same cycle. While the consumer holds off, the register keeps its contents and the input side stalls.

Top module: `alu16_sliced`

## Requirements
- R1: Function code 000 (add) gives result = (A + B) mod 65536, and carry = bit 16 of the 17-bit sum.
- R2: Function code 001 (subtract) gives result = (A − B) mod 65536. Carry is 1 exactly when A ≥ B, unsigned, because it is the carry out of A + ~B + 1.
- R3: Function code 010 gives result = A AND B with carry 0.
- R4: Function code 011 gives result = A OR B with carry 0.
- R5: Function code 100 gives result = A shifted left by one, with bit 0 filled with 0 and carry 0.
- R6: Function code 101 gives result = A shifted right by one, with bit 15 filled with 0 and carry 0.
- R7: Function codes 110 and 111 give result 0, carry 0 and zero flag 1.
- R8: The zero flag is 1 exactly when all 16 result bits are 0, for every function.
- R9: After reset, out_valid is 0 and in_ready is 1. An operation accepted on a clock edge (in_valid and in_ready both high) shows its result with out_valid high after that same edge.
- R10: in_ready equals (not out_valid) or out_ready. While out_valid is 1 and out_ready is 0, the result, carry and zero outputs hold their values, and a presented operation is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and function code are presented |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_a | input | 16 | First operand; also the shift source |
| in_b | input | 16 | Second operand |
| in_func | input | 3 | Function code |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 16 | Registered result |
| out_carry | output | 1 | Registered carry out of the top slice (arithmetic only) |
| out_zero | output | 1 | Registered all-zero flag |

## Verification
The only state is the output register and its valid bit. A broken carry link between slices shows on the first result whose sum crosses a nibble boundary, one edge after acceptance. A wrong decode entry corrupts every result of that function code on its first use. A valid bit that fails to hold under back-pressure either drops a result or overwrites it, and this is visible on the cycle after out_ready falls. Random operands reach most carry chains quickly. Directed all-ones, equal-operand and edge-bit shift cases cover the rest.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'b000,
    FN_SUB = 3'b001,
    FN_AND = 3'b010,
    FN_OR  = 3'b011,
    FN_SHL = 3'b100,
    FN_SHR = 3'b101,
    FN_RS6 = 3'b110,
    FN_RS7 = 3'b111
  } fn_e;

  typedef enum logic [1:0] {
    SOP_ARITH = 2'd0,
    SOP_AND   = 2'd1,
    SOP_OR    = 2'd2
  } slice_op_e;

  typedef enum logic [1:0] {
    OSEL_SLICE = 2'd0,
    OSEL_SHL   = 2'd1,
    OSEL_SHR   = 2'd2,
    OSEL_ZERO  = 2'd3
  } out_sel_e;

  typedef struct packed {
    slice_op_e op;
    logic      inv_b;
    logic      cin;
    out_sel_e  sel;
    logic      carry_en;
  } ctrl_t;
endpackage

// File: rtl/alu_ctrl_rom.sv
module alu_ctrl_rom
  import alu16_pkg::*;
(
  input  logic [2:0] func,
  output ctrl_t      ctrl
);
  // One entry per function code; indexed directly, nothing computed.
  function automatic ctrl_t rom_entry(input logic [2:0] idx);
    ctrl_t e;
    e = '{op: SOP_ARITH, inv_b: 1'b0, cin: 1'b0, sel: OSEL_ZERO, carry_en: 1'b0};
    case (fn_e'(idx))
      FN_ADD: e = '{op: SOP_ARITH, inv_b: 1'b0, cin: 1'b0, sel: OSEL_SLICE, carry_en: 1'b1};
      FN_SUB: e = '{op: SOP_ARITH, inv_b: 1'b1, cin: 1'b1, sel: OSEL_SLICE, carry_en: 1'b1};
      FN_AND: e = '{op: SOP_AND,   inv_b: 1'b0, cin: 1'b0, sel: OSEL_SLICE, carry_en: 1'b0};
      FN_OR:  e = '{op: SOP_OR,    inv_b: 1'b0, cin: 1'b0, sel: OSEL_SLICE, carry_en: 1'b0};
      FN_SHL: e = '{op: SOP_ARITH, inv_b: 1'b0, cin: 1'b0, sel: OSEL_SHL,   carry_en: 1'b0};
      FN_SHR: e = '{op: SOP_ARITH, inv_b: 1'b0, cin: 1'b0, sel: OSEL_SHR,   carry_en: 1'b0};
      default: ;
    endcase
    return e;
  endfunction

  always_comb ctrl = rom_entry(func);
endmodule

// File: rtl/alu_slice4.sv
module alu_slice4
  import alu16_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  slice_op_e    op,
  input  logic         inv_b,
  output logic [W-1:0] f,
  output logic         cout
);
  logic [W-1:0] bx;
  logic [W:0]   sum;

  always_comb begin
    bx  = inv_b ? ~b : b;
    sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
    unique case (op)
      SOP_AND: begin f = a & b; cout = 1'b0; end
      SOP_OR:  begin f = a | b; cout = 1'b0; end
      default: begin f = sum[W-1:0]; cout = sum[W]; end
    endcase
  end

  // Bitwise modes never emit a carry into the next slice
  always_comb begin
    if (op != SOP_ARITH) assert_logic_nocarry_R3: assert (cout == 1'b0);
  end
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
  parameter int W    = 16,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  generate
    if (LEFT) begin : g_left
      assign y = {a[W-2:0], 1'b0};
    end else begin : g_right
      assign y = {1'b0, a[W-1:1]};
    end
  endgenerate
endmodule

// File: rtl/alu16_sliced.sv
module alu16_sliced
  import alu16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [2:0]        in_func,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_zero
);
  localparam int NUM_SLICES = DATA_W / SLICE_W;

  ctrl_t             ctrl;
  logic [NUM_SLICES:0] chain;
  logic [DATA_W-1:0] slice_f, shl_y, shr_y;
  logic [DATA_W-1:0] res_c;
  logic              carry_c, accept;

  alu_ctrl_rom u_rom (.func(in_func), .ctrl(ctrl));

  assign chain[0] = ctrl.cin;

  generate
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      alu_slice4 #(.W(SLICE_W)) u_slice (
        .a    (in_a[s*SLICE_W +: SLICE_W]),
        .b    (in_b[s*SLICE_W +: SLICE_W]),
        .cin  (chain[s]),
        .op   (ctrl.op),
        .inv_b(ctrl.inv_b),
        .f    (slice_f[s*SLICE_W +: SLICE_W]),
        .cout (chain[s+1])
      );
    end
  endgenerate

  alu_shift1 #(.W(DATA_W), .LEFT(1'b1)) u_shl (.a(in_a), .y(shl_y));
  alu_shift1 #(.W(DATA_W), .LEFT(1'b0)) u_shr (.a(in_a), .y(shr_y));

  always_comb begin
    unique case (ctrl.sel)
      OSEL_SLICE: res_c = slice_f;
      OSEL_SHL:   res_c = shl_y;
      OSEL_SHR:   res_c = shr_y;
      default:    res_c = '0;
    endcase
    carry_c = ctrl.carry_en & chain[NUM_SLICES];
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
      out_zero   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= res_c;
        out_carry  <= carry_c;
        out_zero   <= (res_c == '0);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // Assertions
  assert_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_func == 3'b000) |=>
      ({out_carry, out_result} == ({1'b0, $past(in_a)} + {1'b0, $past(in_b)})));

  assert_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_func == 3'b001) |=>
      (out_result == DATA_W'($past(in_a) - $past(in_b))) &&
      (out_carry == ($past(in_a) >= $past(in_b))));

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_func[2:1] == 2'b11) |=> (out_zero && !out_carry && out_result == '0));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_carry) && $stable(out_zero)));
endmodule

// File: tb/alu16_sliced_test.sv
module alu16_sliced_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_a, in_b, out_result;
  logic [2:0]  in_func;
  logic        out_carry, out_zero;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu16_sliced uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_func(in_func), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_carry(out_carry),
    .out_zero(out_zero)
  );

  // Returns {zero, carry, result} from the requirements
  function automatic logic [17:0] model(input logic [15:0] a, b, input logic [2:0] f);
    logic [16:0] s;
    logic [15:0] r;
    logic c;
    c = 1'b0;
    case (f)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[15:0]; c = s[16]; end
      3'd1: begin s = {1'b0, a} + {1'b0, ~b} + 17'd1; r = s[15:0]; c = s[16]; end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = {a[14:0], 1'b0};
      3'd5: r = {1'b0, a[15:1]};
      default: r = 16'h0;
    endcase
    return {(r == 16'h0), c, r};
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] a, b, input logic [2:0] f);
    logic [17:0] e;
    e = model(a, b, f);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_func = f;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", {31'd0, out_valid}, 32'd1);
    check(req_of(f), {15'd0, out_carry, out_result}, {15'd0, e[16:0]});
    check("R8", {31'd0, out_zero}, {31'd0, e[17]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] ea, eb;
    void'($urandom(32'd2718));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_a = '0; in_b = '0; in_func = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {30'd0, out_valid, in_ready}, 32'd1);

    // Directed corners
    run_op(16'hFFFF, 16'h0001, 3'd0);  // R1 full ripple, carry 1, zero 1
    run_op(16'h000F, 16'h0001, 3'd0);  // R1 carry across first slice boundary
    run_op(16'h1234, 16'h1234, 3'd1);  // R2 equal: zero, carry 1
    run_op(16'h0000, 16'h0001, 3'd1);  // R2 borrow: FFFF, carry 0
    run_op(16'hF0F0, 16'h0FF0, 3'd2);  // R3
    run_op(16'hF000, 16'h000F, 3'd3);  // R4
    run_op(16'h8001, 16'hFFFF, 3'd4);  // R5 top bit drops
    run_op(16'h8000, 16'h0000, 3'd4);  // R5 result zero
    run_op(16'h0001, 16'h0000, 3'd5);  // R6 result zero
    run_op(16'h8000, 16'h1111, 3'd5);  // R6 zero fill at top
    run_op(16'hABCD, 16'h1234, 3'd6);  // R7
    run_op(16'hFFFF, 16'hFFFF, 3'd7);  // R7

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = (i % 5 == 0) ? ra : 16'($urandom);
      run_op(ra, rb, 3'($urandom_range(0, 7)));
    end

    // R10 back-pressure
    ea = model(16'h0102, 16'h0304, 3'd0);
    eb = model(16'h00F0, 16'h0F00, 3'd3);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 16'h0102; in_b = 16'h0304; in_func = 3'd0;
    @(negedge clk);
    check("R10", {31'd0, in_ready}, 32'd0);
    in_a = 16'h00F0; in_b = 16'h0F00; in_func = 3'd3;
    @(negedge clk);
    check("R10", {14'd0, out_valid, out_zero, out_carry, out_result}, {14'd0, 1'b1, ea[17:0]});
    @(negedge clk);
    check("R10", {14'd0, out_valid, out_zero, out_carry, out_result}, {14'd0, 1'b1, ea[17:0]});
    out_ready = 1'b1;
    #1;
    check("R10", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", {14'd0, out_valid, out_zero, out_carry, out_result}, {14'd0, 1'b1, eb[17:0]});
    @(negedge clk);
    check("R9", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule